// File: doc/BRIEF.md
# Pipelined Address-Bus Arbiter with Retry Tracking

This block arbitrates a shared address bus among several masters. It also tracks address tenures on a bus where a new tenure may begin in the cycle right after the previous acknowledge, with no dead cycle between them. Each master raises a request. The arbiter answers with a single registered grant. The granted master starts its tenure with a transfer-start pulse, and the tenure stays open until an address acknowledge arrives.

The retry signal is only meaningful in the retry window, which is the single cycle after an acknowledge. A retry seen there cancels the tenure that was just acknowledged. It also cancels any tenure that began in that same window, because such a tenure overlaps the cancelled one. Every cancelled tenure produces one pulse on a retried-flag output.

The cycle after a retry window that carried a retry is the window of opportunity. A master requesting in that cycle is taken to be the snooper that must push data. The arbiter reserves the bus for it and grants it ahead of everyone else. That grant is held back until the cycle after any still-running tenure is acknowledged, so a late acknowledge never lets another master slip in first.

Top module: `addr_arbiter`

## Requirements
- R1: While reset is active, `gnt` is all zeros and `retried` is 0.
- R2: At most one bit of `gnt` is set. Outside a reservation, a new grant goes to the first requesting master found by scanning indices upward from a rotating pointer, wrapping at N. The pointer starts at 0 after reset and moves to one past the granted index.
- R3: A tenure is open from the cycle after `ts` through the cycle of its `aack`. No grant is asserted while a tenure is open. A grant may appear in the cycle right after `aack`. `ts` clears the grant in the next cycle.
- R4: `retry` is sampled only in the cycle after `aack`. A retry there cancels the acknowledged tenure, and `retried` is 1 for exactly the cycle two cycles after that `aack`. A retry in any other cycle has no effect.
- R5: A tenure whose `ts` falls in a retry window that carries a retry is cancelled implicitly. It still needs its own `aack`, and `retried` is 1 in the cycle after that `aack`. A retry in that tenure's own retry window is ignored.
- R6: After a retry window with a valid retry, `gnt` is zero in the next two cycles.
- R7: The lowest-index master requesting in the window of opportunity is reserved. While the reservation holds, no other master is granted. The reserved master is granted first in the cycle after the open tenure's `aack`, or right away if no tenure is open.
- R8: The reservation ends when the reserved master issues `ts`, after which round-robin granting resumes. The reserved grant does not move the rotating pointer.
- R9: If no master requests in the window of opportunity, no reservation is made and ordinary granting resumes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-master bus request |
| ts | input | 1 | Transfer start from the granted master |
| aack | input | 1 | Address acknowledge; ends the open tenure |
| retry | input | 1 | Retry response, sampled in the retry window |
| gnt | output | N | One-hot address-bus grant |
| retried | output | 1 | One-cycle pulse per cancelled tenure |

## Verification
The assertions check on every cycle that the grant is one-hot or empty and that it never overlaps an open tenure. They also check that it drops after a transfer start, that it stays quiet for the two cycles after a valid retry, and that it never goes to anyone but the reserved master while a reservation is held. The bench scenarios are needed to show the timing of each retried pulse, including the implicit one. They also show that stray retries are ignored, that the round-robin order over every request pattern is correct, and that a master requesting after the window waits until the snoop push has started.

// File: rtl/addr_arbiter.sv
module addr_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ts,
  input  logic          aack,
  input  logic          retry,
  output logic [N-1:0]  gnt,
  output logic          retried
);

  logic          busy, imp, rwin, rwin_imp, woo, rsv_v;
  logic [IW-1:0] rsv_id, ptr, ptr_n, pick_id, low_id;
  logic          pick_ok, low_ok;
  logic [N-1:0]  gnt_n;
  logic          ret_x, free, hold;
  int            j;

  assign ret_x = rwin & retry & ~rwin_imp;
  assign free  = ~busy | aack;
  assign hold  = ret_x | woo;

  always_comb begin
    pick_ok = 1'b0;
    pick_id = '0;
    j = 0;
    for (int k = N-1; k >= 0; k--) begin
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (req[j]) begin
        pick_ok = 1'b1;
        pick_id = IW'(j);
      end
    end
  end

  always_comb begin
    low_ok = 1'b0;
    low_id = '0;
    for (int k = N-1; k >= 0; k--)
      if (req[k]) begin
        low_ok = 1'b1;
        low_id = IW'(k);
      end
  end

  always_comb begin
    gnt_n = gnt;
    ptr_n = ptr;
    if (ts || hold) begin
      gnt_n = '0;
    end else if (rsv_v) begin
      gnt_n = '0;
      if (free) gnt_n[rsv_id] = 1'b1;
    end else if (|gnt) begin
      if (!(|(gnt & req))) gnt_n = '0;
    end else if (free && pick_ok) begin
      gnt_n = '0;
      gnt_n[pick_id] = 1'b1;
      ptr_n = (pick_id == IW'(N-1)) ? '0 : pick_id + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt      <= '0;
      ptr      <= '0;
      busy     <= 1'b0;
      imp      <= 1'b0;
      rwin     <= 1'b0;
      rwin_imp <= 1'b0;
      woo      <= 1'b0;
      rsv_v    <= 1'b0;
      rsv_id   <= '0;
      retried  <= 1'b0;
    end else begin
      gnt      <= gnt_n;
      ptr      <= ptr_n;
      rwin     <= aack;
      rwin_imp <= aack & imp;
      woo      <= ret_x;
      retried  <= ret_x | (aack & imp);
      if (ts) begin
        busy <= 1'b1;
        imp  <= ret_x;
      end else if (aack) begin
        busy <= 1'b0;
      end
      if (woo && low_ok) begin
        rsv_v  <= 1'b1;
        rsv_id <= low_id;
      end else if (rsv_v && ts && gnt[rsv_id]) begin
        rsv_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/addr_arbiter_chk.sv
module addr_arbiter_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  gnt,
  input logic          ts,
  input logic          retry,
  input logic          busy,
  input logic          rwin,
  input logic          rwin_imp,
  input logic          rsv_v,
  input logic [IW-1:0] rsv_id
);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_open_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (gnt == '0));

  p_ts_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts |=> (gnt == '0));

  p_window_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rwin && retry && !rwin_imp) |=> (gnt == '0) ##1 (gnt == '0));

  p_reserved_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_v && (gnt != '0)) |-> (gnt == (N'(1) << rsv_id)));

endmodule

bind addr_arbiter addr_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .ts(ts), .retry(retry),
  .busy(busy), .rwin(rwin), .rwin_imp(rwin_imp),
  .rsv_v(rsv_v), .rsv_id(rsv_id)
);

// File: tb/sim_addr_arbiter.sv
`timescale 1ns/1ps
module sim_addr_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         ts = 1'b0, aack = 1'b0, retry = 1'b0;
  logic [N-1:0] gnt;
  logic         retried;

  int n_chk = 0, n_bad = 0, ptr = 0, g = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_arbiter #(.N(N)) u0 (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int rr(input logic [N-1:0] r, input int p);
    for (int k = 0; k < N; k++)
      if (r[(p + k) % N]) return (p + k) % N;
    return -1;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    req = 4'b1111;
    step(); step(); step();
    chk("R1 gnt in reset", 32'(gnt), 0);
    chk("R1 retried in reset", 32'(retried), 0);
    req = '0;
    rst_n = 1'b1;
    step();

    // R2/R3/R4 sweep over every request pattern
    for (int p = 1; p < 16; p++) begin
      req = 4'(p);
      step();
      g = rr(4'(p), ptr);
      chk("R2 round-robin grant", 32'(gnt), 32'(1) << g);
      ptr = (g + 1) % N;
      ts = 1'b1;
      step();
      ts = 1'b0;
      chk("R3 grant cleared by ts", 32'(gnt), 0);
      retry = 1'b1;
      step();
      retry = 1'b0;
      chk("R3 no grant while open", 32'(gnt), 0);
      aack = 1'b1; req = '0;
      step();
      aack = 1'b0;
      chk("R4 stray retry ignored", 32'(retried), 0);
      step();
      chk("R4 no retry in window", 32'(retried), 0);
    end

    // R4-R8: retry with overlapping tenure and a late acknowledge
    req = 4'b0001;
    step();
    g = rr(4'b0001, ptr);
    chk("R2 grant master0", 32'(gnt), 32'(1) << g);
    ptr = (g + 1) % N;
    ts = 1'b1;
    step();
    ts = 1'b0;
    aack = 1'b1;
    step();
    aack = 1'b0;
    g = rr(4'b0001, ptr);
    chk("R3 grant right after aack", 32'(gnt), 32'(1) << g);
    ptr = (g + 1) % N;
    ts = 1'b1; retry = 1'b1; req = '0;
    step();
    ts = 1'b0;
    chk("R6 quiet after retry window", 32'(gnt), 0);
    chk("R4 explicit retried pulse", 32'(retried), 1);
    req = 4'b1010;
    step();
    retry = 1'b0;
    chk("R6 quiet in opportunity window", 32'(gnt), 0);
    chk("R4 retry outside window ignored", 32'(retried), 0);
    req = 4'b1110;
    step();
    chk("R7 push grant held during late tenure", 32'(gnt), 0);
    aack = 1'b1;
    step();
    aack = 1'b0;
    chk("R7 reserved master granted after aack", 32'(gnt), 32'b0010);
    chk("R5 implicit retried pulse", 32'(retried), 1);
    retry = 1'b1;
    step();
    retry = 1'b0;
    chk("R5 retry of implicit tenure ignored", 32'(retried), 0);
    chk("R7 reserved grant kept", 32'(gnt), 32'b0010);
    ts = 1'b1;
    step();
    ts = 1'b0;
    chk("R8 push ts clears grant", 32'(gnt), 0);
    aack = 1'b1; req = 4'b1100;
    step();
    aack = 1'b0;
    g = rr(4'b1100, ptr);
    chk("R8 round-robin resumes", 32'(gnt), 32'(1) << g);
    ptr = (g + 1) % N;
    ts = 1'b1; req = '0;
    step();
    ts = 1'b0; aack = 1'b1;
    step();
    aack = 1'b0;
    step(); step();
    chk("R4 no retried without retry", 32'(retried), 0);

    // R9: retry with nobody in the opportunity window
    req = 4'b0010;
    step();
    g = rr(4'b0010, ptr);
    chk("R2 grant master1", 32'(gnt), 32'(1) << g);
    ptr = (g + 1) % N;
    ts = 1'b1; req = '0;
    step();
    ts = 1'b0; aack = 1'b1;
    step();
    aack = 1'b0; retry = 1'b1;
    step();
    retry = 1'b0;
    chk("R4 explicit retried pulse", 32'(retried), 1);
    step();
    chk("R6 quiet in opportunity window", 32'(gnt), 0);
    req = 4'b1000;
    step();
    g = rr(4'b1000, ptr);
    chk("R9 no reservation, normal grant", 32'(gnt), 32'(1) << g);
    ptr = (g + 1) % N;
    ts = 1'b1; req = '0;
    step();
    ts = 1'b0; aack = 1'b1;
    step();
    aack = 1'b0;
    step(); step();
    chk("R1 idle grant empty", 32'(gnt), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule